// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time in packed BCD and presents it, together with a control byte and general-purpose RAM, as a 64-byte register space with single-byte read and write access. Seconds, minutes, hours, weekday, date, month and year sit at the bottom eight addresses with the control byte. The remaining addresses are plain storage. A host reads a byte by pulsing the read enable for one cycle. The byte appears on the read data port on the next cycle. A write takes effect at the clock edge where the write enable is high.

Time advances from a timing strobe input. The strobe pulses `TICK_DIV` times per second, and an internal sub-second counter divides it down to a once-per-second advance. With `TICK_DIV` set to 1 the strobe is itself the one-second tick. The advance carries through the whole calendar in one step. It handles 12- and 24-hour hour formats, month lengths and leap years. A halt flag stored in the seconds byte freezes the time. The control byte drives three status outputs for a square-wave generator that sits outside this block.

Top module: `bcd_rtc_bank`

## Requirements
- R1: After reset, addresses 0 to 7 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, 0x00 (00:00:00 in 24-hour format, weekday 1, date 01, month 01, year 00, halt clear, control clear). The read data port and all status outputs are 0.
- R2: One cycle after a cycle with `rd_en` high, `rdata` holds the byte at `addr`. `rdata` keeps its value while `rd_en` is low. Reserved bits read as zero: minutes bit 7, hours bit 7, weekday bits 7:3, date bits 7:6, month bits 7:5 and control bits 6, 5, 3, 2.
- R3: A write stores `wdata` at `addr` with its reserved bits forced to zero. The map is: 0 seconds (bit 7 halt, bits 6:0 BCD), 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 control.
- R4: Addresses 0x08 to 0x3F hold any byte written to them and return it on read.
- R5: Seconds advance once for every `TICK_DIV` strobes. A write to address 0 resets the sub-second count to zero and suppresses any advance in that cycle. Without a strobe or a write, the time does not change.
- R6: Seconds and minutes count in BCD from 00 to 59. 59 wraps to 00 and carries into the next field.
- R7: With hours bit 6 clear (24-hour format), hours bits 5:0 count BCD 00 to 23. 23 wraps to 00 and advances the day.
- R8: With hours bit 6 set (12-hour format), bit 5 is PM and bits 4:0 are BCD 1 to 12. 11 goes to 12 with PM toggled, and 12 goes to 01. The day advances only on the change from PM 11 to AM 12.
- R9: On a day advance, the date wraps to 01 after 31 days in months 01, 03, 05, 07, 08, 10 and 12, and after 30 days in months 04, 06, 09 and 11. In month 02 it wraps after 29 days when the year is divisible by 4, and after 28 days otherwise.
- R10: On a day advance, the weekday counts 1 to 7 and 7 wraps to 1. A date wrap advances the month, and month 12 wraps to 01. A month wrap advances the year, and year 99 wraps to 00.
- R11: While seconds bit 7 (halt) is set, strobes are ignored. The time registers and the sub-second count hold their values.
- R12: `out_level` follows control bit 7, `sqw_en` follows control bit 4, and `sqw_rate` follows control bits 1:0.
- R13: A write to a time register in the same cycle as a one-second advance applies the advance first. The written register then takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Timing strobe, `TICK_DIV` pulses per second |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| out_level | output | 1 | Output level setting from control bit 7 |
| sqw_en | output | 1 | Square-wave enable from control bit 4 |
| sqw_rate | output | 2 | Square-wave rate select from control bits 1:0 |

## Verification
Directed calendar starting points test each carry independently. A 24-hour day end on 28 February of a non-leap year tells a 28-day wrap from a 29-day wrap, and the same point in a leap year tells them apart the other way. The last second of the century checks the month and year wraps. The three 12-hour changes (AM 11, PM 11 and AM 12) separate the PM toggle from the day carry. Strobe runs with the halt flag set, and strobe runs after a mid-second write to the seconds register, separate the sub-second count from the seconds field. A random mix of strobes, field rewrites, RAM traffic and reads, compared against a behavioural calendar model, covers orderings that the directed cases miss.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } rtc_time_t;

  localparam int RAM_BASE = 8;
  localparam logic [2:0] CTRL_IDX = 3'd7;

  // Writable bits of each register in the low eight addresses.
  function automatic logic [7:0] rtc_wmask(logic [2:0] idx);
    case (idx)
      3'd0: return 8'hFF;
      3'd1: return 8'h7F;
      3'd2: return 8'h7F;
      3'd3: return 8'h07;
      3'd4: return 8'h3F;
      3'd5: return 8'h1F;
      3'd6: return 8'hFF;
      default: return 8'h93;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last valid date (BCD) for a BCD month and year.
  function automatic logic [7:0] days_in_month(logic [7:0] m, logic [7:0] y);
    logic [3:0] mod_sum;
    mod_sum = {y[6:4], 1'b0} + y[3:0];   // 2*tens + units, same residue mod 4
    case (m)
      8'h02: return (mod_sum[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // One-second advance with the full carry chain.
  function automatic rtc_time_t rtc_advance(rtc_time_t t);
    rtc_time_t n;
    logic c_min, c_hr, c_day, c_mon, c_yr, pm;
    logic [7:0] tmp;
    n = t;
    c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    c_min = (t.sec[6:0] == 7'h59);
    tmp = bcd_inc({1'b0, t.sec[6:0]});
    n.sec = {t.sec[7], c_min ? 7'h00 : tmp[6:0]};
    if (c_min) begin
      if (t.min == 8'h59) begin n.min = 8'h00; c_hr = 1'b1; end
      else n.min = bcd_inc(t.min);
    end
    if (c_hr) begin
      if (t.hour[6]) begin
        pm = t.hour[5];
        if (t.hour[4:0] == 5'h11) begin
          tmp = 8'h12; c_day = pm; pm = ~pm;
        end else if (t.hour[4:0] == 5'h12) begin
          tmp = 8'h01;
        end else begin
          tmp = bcd_inc({3'b000, t.hour[4:0]});
        end
        n.hour = {2'b01, pm, tmp[4:0]};
      end else if (t.hour[5:0] == 6'h23) begin
        n.hour = 8'h00; c_day = 1'b1;
      end else begin
        n.hour = bcd_inc(t.hour);
      end
    end
    if (c_day) begin
      n.wday = (t.wday[2:0] == 3'd7) ? 8'h01 : t.wday + 8'h01;
      if (t.date == days_in_month(t.month, t.year)) begin
        n.date = 8'h01; c_mon = 1'b1;
      end else n.date = bcd_inc(t.date);
    end
    if (c_mon) begin
      if (t.month == 8'h12) begin n.month = 8'h01; c_yr = 1'b1; end
      else n.month = bcd_inc(t.month);
    end
    if (c_yr) n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic halt,
  input  logic clear,
  output logic sec_pulse
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = tick_in & ~halt & ~clear & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick_in && !halt) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       wr_time,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_byte,
  output rtc_time_t  time_q
);
  rtc_time_t advanced;
  rtc_time_t time_d;

  assign advanced = rtc_advance(time_q);

  always_comb begin
    time_d = sec_pulse ? advanced : time_q;
    if (wr_time) begin
      case (wr_idx)
        3'd0: time_d.sec   = wr_byte;
        3'd1: time_d.min   = wr_byte;
        3'd2: time_d.hour  = wr_byte;
        3'd3: time_d.wday  = wr_byte;
        3'd4: time_d.date  = wr_byte;
        3'd5: time_d.month = wr_byte;
        3'd6: time_d.year  = wr_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                            date: 8'h01, month: 8'h01, year: 8'h00};
    else time_q <= time_d;
  end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int DEPTH = 56,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/bcd_rtc_bank.sv
module bcd_rtc_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              out_level,
  output logic              sqw_en,
  output logic [1:0]        sqw_rate
);
  localparam int SPACE     = 1 << ADDR_W;
  localparam int RAM_DEPTH = SPACE - RAM_BASE;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  logic              is_ram;
  logic [2:0]        reg_idx;
  logic [7:0]        wbyte;
  logic              wr_time, wr_ctrl, wr_sec, wr_ram;
  logic [RAM_AW-1:0] ram_idx;
  logic [7:0]        ram_byte;
  logic [7:0]        ctrl_q;
  logic [7:0]        rd_byte;
  logic              sec_pulse;
  rtc_time_t         time_q;

  assign is_ram  = (addr >= ADDR_W'(RAM_BASE));
  assign reg_idx = addr[2:0];
  assign wbyte   = wdata & rtc_wmask(reg_idx);
  assign wr_time = wr_en & ~is_ram & (reg_idx != CTRL_IDX);
  assign wr_ctrl = wr_en & ~is_ram & (reg_idx == CTRL_IDX);
  assign wr_sec  = wr_time & (reg_idx == 3'd0);
  assign wr_ram  = wr_en & is_ram;
  assign ram_idx = RAM_AW'(addr - ADDR_W'(RAM_BASE));

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .halt(time_q.sec[7]),
    .clear(wr_sec), .sec_pulse(sec_pulse)
  );

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .wr_time(wr_time),
    .wr_idx(reg_idx), .wr_byte(wbyte), .time_q(time_q)
  );

  rtc_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(wr_ram), .idx(ram_idx), .wdata(wdata), .rdata(ram_byte)
  );

  always_comb begin
    if (is_ram) rd_byte = ram_byte;
    else begin
      case (reg_idx)
        3'd0: rd_byte = time_q.sec;
        3'd1: rd_byte = time_q.min;
        3'd2: rd_byte = time_q.hour;
        3'd3: rd_byte = time_q.wday;
        3'd4: rd_byte = time_q.date;
        3'd5: rd_byte = time_q.month;
        3'd6: rd_byte = time_q.year;
        default: rd_byte = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      rdata  <= 8'h00;
    end else begin
      if (wr_ctrl) ctrl_q <= wbyte;
      if (rd_en) rdata <= rd_byte;
    end
  end

  assign out_level = ctrl_q[7];
  assign sqw_en    = ctrl_q[4];
  assign sqw_rate  = ctrl_q[1:0];
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              out_level,
  input logic              sqw_en,
  input logic [1:0]        sqw_rate,
  input logic              sec_pulse,
  input rtc_time_t         time_q
);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_wday_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(3)) |=> (rdata[7:3] == 5'b0));

  assert_time_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !wr_en) |=> $stable(time_q));

  assert_sec_write_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |-> !sec_pulse);

  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_en && time_q.sec[6:0] == 7'h59) |=> (time_q.sec[6:0] == 7'h00));

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.sec[7] && !wr_en) |=> $stable(time_q));

  assert_halt_nopulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    time_q.sec[7] |-> !sec_pulse);

  assert_ctrl_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(7)) |=> $stable({out_level, sqw_en, sqw_rate}));
endmodule

bind bcd_rtc_bank rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .out_level(out_level), .sqw_en(sqw_en), .sqw_rate(sqw_rate),
  .sec_pulse(sec_pulse), .time_q(time_q)
);

// File: tb/test_bcd_rtc_bank.sv
module test_bcd_rtc_bank;
  localparam int DIV = 4;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_in = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    rdata;
  logic          out_level, sqw_en;
  logic [1:0]    sqw_rate;

  bcd_rtc_bank #(.ADDR_W(AW), .TICK_DIV(DIV)) i_bcd_rtc_bank (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .out_level(out_level),
    .sqw_en(sqw_en), .sqw_rate(sqw_rate)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural model: hour kept as 0..23 whatever the display format.
  int m_sec = 0, m_min = 0, m_hr = 0, m_wday = 1, m_date = 1, m_mon = 1, m_yr = 0;
  int m_sub = 0;
  bit m_ch = 0, m_12 = 0;
  logic [7:0] m_ctrl = 8'h00;
  logic [7:0] m_ram [64];

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_len(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    int h12;
    logic [7:0] s;
    h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
    case (a)
      0: begin s = bcd(m_sec); return {m_ch, s[6:0]}; end
      1: return bcd(m_min);
      2: begin
        s = bcd(h12);
        return m_12 ? {2'b01, (m_hr >= 12), s[4:0]} : bcd(m_hr);
      end
      3: return 8'(m_wday);
      4: return bcd(m_date);
      5: return bcd(m_mon);
      6: return bcd(m_yr);
      7: return m_ctrl & 8'h93;
      default: return m_ram[a];
    endcase
  endfunction

  task automatic m_adv();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wday = (m_wday == 7) ? 1 : m_wday + 1;
          m_date++;
          if (m_date > month_len(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic m_tick();
    if (!m_ch) begin
      if (m_sub == DIV - 1) begin m_sub = 0; m_adv(); end
      else m_sub++;
    end
  endtask

  task automatic m_write(int a, logic [7:0] d);
    int h12;
    case (a)
      0: begin m_ch = d[7]; m_sec = unbcd({1'b0, d[6:0]}); m_sub = 0; end
      1: m_min = unbcd(d);
      2: begin
        m_12 = d[6];
        if (m_12) begin
          h12 = unbcd({3'b000, d[4:0]});
          m_hr = (h12 % 12) + (d[5] ? 12 : 0);
        end else m_hr = unbcd({2'b00, d[5:0]});
      end
      3: m_wday = int'(d[2:0]);
      4: m_date = unbcd(d);
      5: m_mon = unbcd(d);
      6: m_yr = unbcd(d);
      7: m_ctrl = d;
      default: m_ram[a] = d;
    endcase
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
    m_write(a, d);
  endtask

  task automatic do_tick();
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    m_tick();
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic do_wr_tick(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; tick_in = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; tick_in = 1'b0;
    if (a != 0) m_tick();
    m_write(a, d);
  endtask

  task automatic do_rd(int a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(negedge clk); rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic chk_reg(string tag, int a);
    logic [7:0] v;
    do_rd(a, v);
    check($sformatf("%s addr %0d", tag, a), v, exp_reg(a));
  endtask

  task automatic chk_time(string tag);
    for (int a = 0; a < 7; a++) chk_reg(tag, a);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] wd,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    do_wr(1, mi); do_wr(2, h); do_wr(3, wd); do_wr(4, dt);
    do_wr(5, mo); do_wr(6, y); do_wr(0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r, a;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 rdata at reset", rdata, 8'h00);
    check("R1 outputs at reset", {5'b0, out_level, sqw_en, sqw_rate[1]}, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) chk_reg("R1 reset value", i);

    // R12 control outputs and R2 reserved control bits
    do_wr(7, 8'hFF);
    chk_reg("R2 control reserved", 7);
    check("R12 status", {5'b0, out_level, sqw_en, 1'b0}, 8'h06);
    check("R12 rate", {6'b0, sqw_rate}, 8'h03);
    do_wr(7, 8'h12);
    check("R12 status after rewrite", {4'b0, out_level, sqw_en, sqw_rate}, 8'h06);
    // R3 masked write, R2 rdata hold
    do_wr(3, 8'hFD);
    do_rd(3, v); check("R3 weekday masked", v, 8'h05);
    repeat (3) @(negedge clk);
    check("R2 rdata held", rdata, 8'h05);
    do_wr(1, 8'hD9);
    do_rd(1, v); check("R3 minutes bit7 dropped", v, 8'h59);

    // R4 RAM fill and readback
    for (int i = 8; i < 64; i++) do_wr(i, 8'($urandom));
    for (int i = 8; i < 64; i++) chk_reg("R4 ram", i);

    // R5 prescaler
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    do_ticks(DIV - 1);
    do_rd(0, v); check("R5 before full second", v, 8'h00);
    do_tick();
    do_rd(0, v); check("R5 one second", v, 8'h01);
    do_ticks(DIV - 1);
    do_wr(0, 8'h10);
    do_ticks(DIV - 1);
    do_rd(0, v); check("R5 sub-second cleared by write", v, 8'h10);
    do_tick();
    do_rd(0, v); check("R5 second after clear", v, 8'h11);

    // R6 R7 R9 R10: end of non-leap February, weekday 7
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    do_ticks(2 * DIV);
    chk_time("R6 R7 R9 R10 day end");
    do_rd(4, v); check("R9 non-leap Feb wrap", v, 8'h01);
    do_rd(3, v); check("R10 weekday wrap", v, 8'h01);
    // leap year
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    do_ticks(DIV);
    do_rd(4, v); check("R9 leap Feb 29", v, 8'h29);
    chk_time("R9 leap");
    // 30-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h11);
    do_ticks(DIV);
    chk_time("R9 30-day month");
    // century
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    do_ticks(DIV);
    do_rd(6, v); check("R10 year wrap", v, 8'h00);
    do_rd(5, v); check("R10 month wrap", v, 8'h01);
    chk_time("R10 century");

    // R8 12-hour format
    set_time(8'h59, 8'h59, 8'h71, 8'h04, 8'h15, 8'h06, 8'h30);
    do_ticks(DIV);
    do_rd(2, v); check("R8 PM 11 to AM 12", v, 8'h52);
    do_rd(4, v); check("R8 day carry", v, 8'h16);
    set_time(8'h59, 8'h59, 8'h51, 8'h04, 8'h15, 8'h06, 8'h30);
    do_ticks(DIV);
    do_rd(2, v); check("R8 AM 11 to PM 12", v, 8'h72);
    do_rd(4, v); check("R8 no day carry", v, 8'h15);
    set_time(8'h59, 8'h59, 8'h52, 8'h04, 8'h15, 8'h06, 8'h30);
    do_ticks(DIV);
    do_rd(2, v); check("R8 12 to 01", v, 8'h41);

    // R11 halt
    do_wr(0, 8'h85);
    do_ticks(3 * DIV);
    do_rd(0, v); check("R11 halted seconds", v, 8'h85);
    chk_time("R11 halted");
    do_wr(0, 8'h05);
    do_ticks(DIV);
    do_rd(0, v); check("R11 resumed", v, 8'h06);

    // R13 write coinciding with an advance
    do_wr(0, 8'h20);
    do_ticks(DIV - 1);
    do_wr_tick(1, 8'h30);
    do_rd(0, v); check("R13 advance applied", v, 8'h21);
    do_rd(1, v); check("R13 written value kept", v, 8'h30);

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      r = int'($urandom % 10);
      case (r)
        0, 1, 2, 3: do_ticks(1 + int'($urandom % 8));
        4: do_wr(8 + int'($urandom % 56), 8'($urandom));
        5: chk_reg("R4 random ram", 8 + int'($urandom % 56));
        6, 7: chk_reg("R6 random time", int'($urandom % 8));
        8: do_wr(1, bcd(int'($urandom % 60)));
        default: begin
          a = int'($urandom % 12) + 1;
          if ($urandom % 2 == 0) do_wr(2, {2'b01, 1'($urandom), bcd(a) & 8'h1F});
          else do_wr(2, bcd(int'($urandom % 24)));
          do_wr(0, bcd(50 + int'($urandom % 10)));
        end
      endcase
    end
    chk_time("R7 random end");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule